// File: doc/BRIEF.md
# Two-Class Open-Row-Aware Memory Request Scheduler

This block sits in front of a DRAM channel and decides which pending memory request goes out next. Every incoming request carries a bank number, a row number, an arrival stamp and a one-bit class flag. The class flag is set upstream from the hit behaviour of the issuing warp. Warps that hit always or nearly always are urgent. Warps that are balanced, miss mostly or miss always are not. Urgent requests wait in one queue and the rest in another, and the urgent queue always wins.

Inside each queue the scheduler prefers requests that would reuse a row already open in its bank. Among those it takes the one that arrived first. When no pending request in that queue hits an open row, it takes the one that arrived first overall. The block tracks one open row per bank and updates it whenever a request is issued. It models no other DRAM timing. Requests enter through a valid/ready port and leave through another valid/ready port, at most one per cycle.

Top module: `mem_prio_sched`

## Requirements
- R1: A request accepted with `enq_prio`=1 is held in the urgent queue, and one accepted with `enq_prio`=0 is held in the normal queue. Each request leaves with its own class on `iss_prio`.
- R2: While the urgent queue holds any request, every issued request comes from the urgent queue (`iss_prio`=1).
- R3: Within the chosen queue, if any request's row equals the open row of its bank, the issued request is such a row hit, and it is the hit with the lowest arrival stamp.
- R4: Within the chosen queue, if no request hits an open row, the issued request is the one with the lowest arrival stamp, regardless of the order in which the requests were accepted.
- R5: An issue handshake (`iss_valid` and `iss_ready` both high on a clock edge) makes the issued row the open row of the issued bank from the next cycle on.
- R6: Each queue holds at most 8 requests. `enq_ready` is low for a class whose queue is full and high otherwise. A request offered while its queue is full is dropped and is never issued, and the other class is still accepted.
- R7: After reset both queues are empty, no bank has an open row, `iss_valid` is low and `enq_ready` is high for both classes.
- R8: `iss_valid` is high exactly when at least one request is queued. A request accepted on a clock edge can be issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Incoming request present |
| enq_ready | output | 1 | Queue for the offered class has room |
| enq_prio | input | 1 | Class flag, 1 = urgent queue |
| enq_bank | input | 2 | Target bank |
| enq_row | input | 8 | Target row |
| enq_age | input | 16 | Arrival stamp, lower is older |
| iss_valid | output | 1 | A request is offered to DRAM |
| iss_ready | input | 1 | DRAM side takes the offered request |
| iss_prio | output | 1 | Class of the offered request |
| iss_bank | output | 2 | Bank of the offered request |
| iss_row | output | 8 | Row of the offered request |
| iss_age | output | 16 | Arrival stamp of the offered request |

## Verification
The bench uses the default build: four banks, 8-bit rows, 16-bit stamps and eight entries per queue. Eight entries are few enough that a directed test fills the urgent queue and sees the refusal, then sees the other class still accepted. Four banks are enough to mix requests that hit, miss and find no open row. The stamps are wide, so the bench can hand them out out of order and show that selection follows the stamp and not the slot order.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int BANK_W = 2;
  parameter int ROW_W  = 8;
  parameter int AGE_W  = 16;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef struct packed {
    logic              prio;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [AGE_W-1:0]  age;
  } req_t;
endpackage

// File: rtl/req_queue.sv
module req_queue
  import sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  req_t                         wr_req,
  input  logic                         pop_en,
  input  logic [$clog2(DEPTH)-1:0]     pop_idx,
  output logic [DEPTH-1:0]             vld,
  output req_t [DEPTH-1:0]             ent,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0] vld_nxt;
  req_t [DEPTH-1:0] ent_nxt;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CNT_W'(vld[i]);
  end

  assign full = ~free_any;

  always_comb begin
    vld_nxt = vld;
    ent_nxt = ent;
    if (pop_en) vld_nxt[pop_idx] = 1'b0;
    if (wr_en && free_any) begin
      vld_nxt[free_idx] = 1'b1;
      ent_nxt[free_idx] = wr_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_nxt;
  end

  // payload storage needs no reset; guarded by vld
  always_ff @(posedge clk) begin
    if (wr_en && free_any) ent[free_idx] <= ent_nxt[free_idx];
  end

  // occupancy moves by exactly the accepted writes and pops (R6)
  assert_occupancy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(vld) ==
              $countones($past(vld)) + int'($past(wr_en)) - int'($past(pop_en))));

  // never more than DEPTH entries, a full queue refuses writes (R6)
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_en) |=> (vld == $past(vld)));
endmodule

// File: rtl/frfcfs_pick.sv
module frfcfs_pick
  import sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]                    vld,
  input  req_t [DEPTH-1:0]                    ent,
  input  logic [NUM_BANKS-1:0]                open_vld,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row,
  output logic                                sel_vld,
  output logic [$clog2(DEPTH)-1:0]            sel_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] hit;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx, old_idx;
  logic             hit_fnd, old_fnd;
  logic [AGE_W-1:0] hit_age, old_age;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign hit[g] = vld[g] && open_vld[ent[g].bank] &&
                      (open_row[ent[g].bank] == ent[g].row);
    end
  endgenerate

  assign hit_any = |hit;

  // oldest row hit; a strictly lower stamp replaces, so lower slot keeps ties
  always_comb begin
    hit_idx = '0;
    hit_fnd = 1'b0;
    hit_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i] && (!hit_fnd || ent[i].age < hit_age)) begin
        hit_idx = IDX_W'(i);
        hit_age = ent[i].age;
        hit_fnd = 1'b1;
      end
    end
  end

  // oldest overall
  always_comb begin
    old_idx = '0;
    old_fnd = 1'b0;
    old_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (!old_fnd || ent[i].age < old_age)) begin
        old_idx = IDX_W'(i);
        old_age = ent[i].age;
        old_fnd = 1'b1;
      end
    end
  end

  assign sel_vld = |vld;
  assign sel_idx = hit_any ? hit_idx : old_idx;

  // R3: any row hit present means the chosen entry is a hit
  always_comb begin
    if (sel_vld && hit_any)
      assert_hit_first_R3: assert (hit[sel_idx]);
  end

  // R4: without hits no pending entry is older than the chosen one
  always_comb begin
    if (sel_vld && !hit_any) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i]) assert_oldest_R4: assert (!(ent[i].age < ent[sel_idx].age));
      end
    end
  end
endmodule

// File: rtl/open_row_tbl.sv
module open_row_tbl
  import sched_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             upd_en,
  input  logic [BANK_W-1:0]                upd_bank,
  input  logic [ROW_W-1:0]                 upd_row,
  output logic [NUM_BANKS-1:0]             open_vld,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row
);
  logic [NUM_BANKS-1:0]            vld_nxt;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_nxt;

  always_comb begin
    vld_nxt = open_vld;
    row_nxt = open_row;
    if (upd_en) begin
      vld_nxt[upd_bank] = 1'b1;
      row_nxt[upd_bank] = upd_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld <= '0;
      open_row <= '0;
    end else if (upd_en) begin
      open_vld <= vld_nxt;
      open_row <= row_nxt;
    end
  end

  assert_row_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (open_vld[$past(upd_bank)] &&
                open_row[$past(upd_bank)] == $past(upd_row)));
endmodule

// File: rtl/mem_prio_sched.sv
module mem_prio_sched
  import sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic              enq_prio,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [AGE_W-1:0]  enq_age,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_prio,
  output logic [BANK_W-1:0] iss_bank,
  output logic [ROW_W-1:0]  iss_row,
  output logic [AGE_W-1:0]  iss_age
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int NQ    = 2;   // queue 1 = urgent, queue 0 = normal

  req_t                            enq_req;
  logic [NUM_BANKS-1:0]            open_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
  logic [NQ-1:0]                   q_full, q_wr, q_pop, q_sel_vld;
  logic [NQ-1:0][DEPTH-1:0]        q_vld;
  req_t [NQ-1:0][DEPTH-1:0]        q_ent;
  logic [NQ-1:0][IDX_W-1:0]        q_sel_idx;
  logic [NQ-1:0][CNT_W-1:0]        q_cnt;
  logic                            use_hi, iss_fire;
  req_t                            iss_req;

  assign enq_req.prio = enq_prio;
  assign enq_req.bank = enq_bank;
  assign enq_req.row  = enq_row;
  assign enq_req.age  = enq_age;

  assign enq_ready = ~q_full[enq_prio];

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_q
      assign q_wr[q] = enq_valid && enq_ready && (enq_prio == q[0]);

      req_queue #(.DEPTH(DEPTH)) i_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr[q]),
        .wr_req  (enq_req),
        .pop_en  (q_pop[q]),
        .pop_idx (q_sel_idx[q]),
        .vld     (q_vld[q]),
        .ent     (q_ent[q]),
        .full    (q_full[q]),
        .cnt     (q_cnt[q])
      );

      frfcfs_pick #(.DEPTH(DEPTH)) i_pick (
        .vld      (q_vld[q]),
        .ent      (q_ent[q]),
        .open_vld (open_vld),
        .open_row (open_row),
        .sel_vld  (q_sel_vld[q]),
        .sel_idx  (q_sel_idx[q])
      );
    end
  endgenerate

  // strict class priority
  assign use_hi    = q_sel_vld[1];
  assign iss_valid = q_sel_vld[1] | q_sel_vld[0];
  assign iss_req   = use_hi ? q_ent[1][q_sel_idx[1]] : q_ent[0][q_sel_idx[0]];
  assign iss_fire  = iss_valid && iss_ready;
  assign q_pop[1]  = iss_fire && use_hi;
  assign q_pop[0]  = iss_fire && !use_hi;

  assign iss_prio = iss_req.prio;
  assign iss_bank = iss_req.bank;
  assign iss_row  = iss_req.row;
  assign iss_age  = iss_req.age;

  open_row_tbl i_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (iss_fire),
    .upd_bank (iss_req.bank),
    .upd_row  (iss_req.row),
    .open_vld (open_vld),
    .open_row (open_row)
  );

  assert_strict_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_prio) |-> (q_vld[1] == '0));

  assert_class_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && enq_prio && !q_pop[1]) |=>
      (q_cnt[1] == $past(q_cnt[1]) + CNT_W'(1)));

  assert_valid_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt[0] != '0 || q_cnt[1] != '0) |-> iss_valid);
endmodule

// File: tb/test_mem_prio_sched.sv
`timescale 1ns/100ps
module test_mem_prio_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid, enq_ready, enq_prio;
  logic [1:0]  enq_bank;
  logic [7:0]  enq_row;
  logic [15:0] enq_age;
  logic        iss_valid, iss_ready, iss_prio;
  logic [1:0]  iss_bank;
  logic [7:0]  iss_row;
  logic [15:0] iss_age;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mem_prio_sched i_mem_prio_sched (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_prio(enq_prio),
    .enq_bank(enq_bank), .enq_row(enq_row), .enq_age(enq_age),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_prio(iss_prio),
    .iss_bank(iss_bank), .iss_row(iss_row), .iss_age(iss_age)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // offer one request; called and returns on a falling edge
  task automatic enq(input bit p, input int b, input int r, input int a,
                     input bit exp_rdy, input string req);
    enq_valid = 1'b1; enq_prio = p;
    enq_bank = 2'(b); enq_row = 8'(r); enq_age = 16'(a);
    #1;
    check(enq_ready == exp_rdy, req, "enq_ready", int'(enq_ready), int'(exp_rdy));
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  // expect an offered request, then take it
  task automatic take(input bit p, input int b, input int r, input int a,
                      input string req);
    bit ok;
    ok = iss_valid && iss_prio == p && int'(iss_bank) == b &&
         int'(iss_row) == r && int'(iss_age) == a;
    if (!ok)
      $display("  offered v=%0d p=%0d b=%0d r=%0d a=%0d", iss_valid, iss_prio,
               iss_bank, iss_row, iss_age);
    check(ok, req, "issued age", int'(iss_age), a);
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic t_reset;
    check(iss_valid == 1'b0, "R7", "iss_valid after reset", int'(iss_valid), 0);
    enq_prio = 1'b1; #0.5;
    check(enq_ready == 1'b1, "R7", "urgent ready after reset", int'(enq_ready), 1);
    enq_prio = 1'b0; #0.5;
    check(enq_ready == 1'b1, "R7", "normal ready after reset", int'(enq_ready), 1);
  endtask

  // open rows afterwards: bank0=9, bank1=7
  task automatic t_priority;
    enq(0, 0, 9, 1, 1, "R1");
    enq(0, 0, 5, 2, 1, "R1");
    enq(1, 0, 5, 3, 1, "R1");
    enq(1, 1, 7, 4, 1, "R1");
    check(iss_valid == 1'b1, "R8", "iss_valid with requests", int'(iss_valid), 1);
    take(1, 0, 5, 3, "R2");   // urgent first although normal ones are older
    take(1, 1, 7, 4, "R2");
    take(0, 0, 5, 2, "R5");   // bank0 row 5 opened by the urgent issue
    take(0, 0, 9, 1, "R1");
    check(iss_valid == 1'b0, "R8", "iss_valid drained", int'(iss_valid), 0);
  endtask

  // open rows afterwards: bank0=3, bank1=30, bank2=1, bank3=2
  task automatic t_oldest;
    enq(0, 2, 1, 10, 1, "R4");
    enq(0, 3, 2, 11, 1, "R4");
    enq(0, 0, 3, 12, 1, "R4");
    take(0, 2, 1, 10, "R4");
    take(0, 3, 2, 11, "R4");
    take(0, 0, 3, 12, "R4");
    enq(0, 1, 30, 22, 1, "R4");
    enq(0, 1, 31, 21, 1, "R4");
    enq(0, 1, 32, 20, 1, "R4");
    take(0, 1, 32, 20, "R4"); // stamp order, not slot order
    take(0, 1, 31, 21, "R4");
    take(0, 1, 30, 22, "R4");
  endtask

  // open rows afterwards: bank3=9
  task automatic t_hits;
    enq(1, 3, 9, 39, 1, "R3");
    enq(1, 2, 1, 41, 1, "R3");
    enq(1, 0, 3, 40, 1, "R3");
    take(1, 0, 3, 40, "R3");  // oldest hit beats older miss
    take(1, 2, 1, 41, "R3");
    take(1, 3, 9, 39, "R4");
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) enq(1, 0, 3, 50 + i, 1, "R6");
    enq(1, 0, 3, 99, 0, "R6");  // refused
    enq(0, 0, 3, 60, 1, "R6");  // other class still accepted
    for (int i = 0; i < 8; i++) take(1, 0, 3, 50 + i, "R6");
    take(0, 0, 3, 60, "R6");
    check(iss_valid == 1'b0, "R6", "refused request issued", int'(iss_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; enq_valid = 1'b0; enq_prio = 1'b0; enq_bank = '0;
    enq_row = '0; enq_age = '0; iss_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_priority;
    t_oldest;
    t_hits;
    t_full;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule